// File: doc/BRIEF.md
# Wake Interrupt Polarity Normalizer

A bank of per-pin conditioners placed between raw, asynchronous wake-capable interrupt lines and a downstream interrupt controller that only understands active-high levels and rising-edge requests. Each pin has a trigger-type code and an enable bit. The block turns active-low levels into active-high levels. It turns falling edges into single-cycle rising pulses, and it turns both transitions of a dual-edge pin into such pulses. It forces the output of a disabled pin to zero and drops the edges that arrive while the pin is disabled.

Every raw line is first passed through a two-flop synchronizer. Each pin runs a small state machine with three states. `PIN_OFF` means the pin is disabled and its output is held at 0. `PIN_SETTLE` is a one-cycle quiet state entered after an accepted type write, with the output held at 0. `PIN_RUN` means the pin is conditioning. The transitions are: OFF→RUN when the enable is set; RUN→OFF when the enable is cleared; any state→SETTLE on an accepted type write; SETTLE→RUN or SETTLE→OFF according to the enable; and a state stays where it is otherwise. While the pin settles, the edge history keeps following the synchronized input, so changing the polarity cannot manufacture an edge.

Configuration goes through a simple synchronous register port. Addresses are byte addresses and only word-aligned accesses hit. Read data is registered and is valid on the cycle after the read strobe.

Top module: `wake_irq_normalizer`

## Requirements
- R1: After reset all enable bits read 0, every type register reads 3'b100 (active-high level), and all `irq_out` bits are 0.
- R2: The enable bit of pin p is bit p%32 of the word at byte address 0x10 + 4*(p/32). Enable bits for pins that do not exist read 0 and cannot be set. Any address that decodes to no register reads 0.
- R3: The type code of pin p is held in bits [2:0] of the word at byte address 0x110 + 4*p. The legal codes are 3'b000 active-low level, 3'b010 falling edge, 3'b100 active-high level, 3'b110 rising edge and 3'b111 both edges. A write of 3'b001, 3'b011 or 3'b101 leaves the register unchanged. A read returns the last accepted code.
- R4: For an enabled active-high level pin, `irq_out[p]` equals the raw input, delayed so that a change applied before clock edge k shows after edge k+2.
- R5: For an enabled active-low level pin, `irq_out[p]` equals the inverted raw input, with the latency of R4.
- R6: For an enabled rising-edge pin, a 0→1 input transition gives exactly one high cycle on `irq_out[p]`, starting after edge k+2. A 1→0 transition gives none.
- R7: For an enabled falling-edge pin, a 1→0 transition gives exactly one high cycle, timed as in R6. A 0→1 transition gives none.
- R8: For an enabled dual-edge pin, each transition in either direction gives exactly one high cycle, timed as in R6.
- R9: While a pin is disabled, its output is 0. An edge that happens while the pin is disabled is dropped and is not delivered when the pin is enabled again. A level pin resumes following its input after it is enabled again.
- R10: An accepted type write to pin p holds `irq_out[p]` at 0 for the cycle after the write. It never produces an edge pulse by itself, even when the new polarity differs from the old one while the input is held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| wake_in | input | NUM_PINS | Raw asynchronous interrupt inputs |
| irq_out | output | NUM_PINS | Normalized requests toward the downstream controller |

## Verification
Each trigger type is driven with a steady rise and a steady fall of its input, and the five-cycle output window that follows is compared with the expected pattern. This separates level from pulse behaviour, correct from inverted polarity, and edges taken from edges ignored. Retyping a pin while its input is held steady checks that a polarity swap yields no pulse and that the output drops for exactly one cycle. Toggling the enable around an input edge shows that the edge is dropped rather than stored. Partial enable words and illegal type codes are read back through the register port.

// File: rtl/wkn_pkg.sv
package wkn_pkg;

    typedef enum logic [2:0] {
        TY_LVL_LO    = 3'b000,
        TY_EDGE_FALL = 3'b010,
        TY_LVL_HI    = 3'b100,
        TY_EDGE_RISE = 3'b110,
        TY_EDGE_BOTH = 3'b111
    } trig_type_e;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_SETTLE = 2'd1,
        PIN_RUN    = 2'd2
    } pin_state_e;

    function automatic logic code_ok(input logic [2:0] c);
        return (c == TY_LVL_LO) || (c == TY_EDGE_FALL) || (c == TY_LVL_HI) ||
               (c == TY_EDGE_RISE) || (c == TY_EDGE_BOTH);
    endfunction

endpackage

// File: rtl/wkn_regs.sv
module wkn_regs
    import wkn_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12,
    parameter int EN_BASE  = 'h10,
    parameter int TY_BASE  = 'h110
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [NUM_PINS-1:0]      en_q,
    output logic [NUM_PINS-1:0][2:0] ty_q,
    output logic [NUM_PINS-1:0]      cfg_wr
);

    localparam int WI_W = ADDR_W - 2;

    logic [WI_W-1:0] wi;
    logic            aligned;
    logic [31:0]     rd_word;

    assign wi      = reg_addr[ADDR_W-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [WI_W-1:0] EN_WI = WI_W'(EN_BASE / 4 + p / 32);
        localparam logic [WI_W-1:0] TY_WI = WI_W'(TY_BASE / 4 + p);
        localparam int BIT_POS = p % 32;

        logic ty_hit;
        assign ty_hit    = reg_wr && aligned && (wi == TY_WI);
        assign cfg_wr[p] = ty_hit && code_ok(reg_wdata[2:0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[p] <= 1'b0;
            end else if (reg_wr && aligned && (wi == EN_WI)) begin
                en_q[p] <= reg_wdata[BIT_POS];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ty_q[p] <= TY_LVL_HI;
            end else if (cfg_wr[p]) begin
                ty_q[p] <= reg_wdata[2:0];
            end
        end

        // R3: an unlisted code does not alter the stored type
        a_r3_bad_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (ty_hit && !code_ok(reg_wdata[2:0])) |=> $stable(ty_q[p]));

        // R3: an accepted code is what the register then holds
        a_r3_code_stored: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_wr[p] |=> (ty_q[p] == $past(reg_wdata[2:0])));
    end

    always_comb begin
        rd_word = '0;
        if (aligned) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wi == WI_W'(EN_BASE / 4 + p / 32)) begin
                    rd_word[p % 32] = en_q[p];
                end
                if (wi == WI_W'(TY_BASE / 4 + p)) begin
                    rd_word[2:0] = ty_q[p];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/wkn_pin.sv
module wkn_pin
    import wkn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic       pin_en,
    input  logic [2:0] cfg,
    input  logic       cfg_wr,
    output logic       irq
);

    pin_state_e st_q, st_d;
    logic       sy1, sy2, hist;
    logic       cond, irq_d;

    // two-flop synchronizer and one-deep edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy1  <= 1'b0;
            sy2  <= 1'b0;
            hist <= 1'b0;
        end else begin
            sy1  <= raw_in;
            sy2  <= sy1;
            hist <= sy2;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PIN_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_OFF: begin
                if (cfg_wr)      st_d = PIN_SETTLE;
                else if (pin_en) st_d = PIN_RUN;
            end
            PIN_SETTLE: begin
                if (cfg_wr)      st_d = PIN_SETTLE;
                else if (pin_en) st_d = PIN_RUN;
                else             st_d = PIN_OFF;
            end
            PIN_RUN: begin
                if (cfg_wr)       st_d = PIN_SETTLE;
                else if (!pin_en) st_d = PIN_OFF;
            end
            default: st_d = PIN_OFF;
        endcase
    end

    // output process: normalized condition per trigger type
    always_comb begin
        unique case (cfg)
            TY_EDGE_FALL: cond = hist & ~sy2;
            TY_EDGE_RISE: cond = sy2 & ~hist;
            TY_EDGE_BOTH: cond = sy2 ^ hist;
            TY_LVL_LO:    cond = ~sy2;
            default:      cond = sy2;
        endcase
        irq_d = (st_q == PIN_RUN) && pin_en && cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= irq_d;
        end
    end

    // R9: a disabled pin is quiet on the next cycle
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> !irq);

    // R10: the cycle after an accepted type write is held low
    a_r10_settle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ##1 !irq);

    // R6 / R7: single-edge pulses last one cycle
    a_r6_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (((cfg == TY_EDGE_RISE) || (cfg == TY_EDGE_FALL)) && irq) |=> !irq);

endmodule

// File: rtl/wake_irq_normalizer.sv
module wake_irq_normalizer
    import wkn_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12,
    parameter int EN_BASE  = 'h10,
    parameter int TY_BASE  = 'h110
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] wake_in,
    output logic [NUM_PINS-1:0] irq_out
);

    logic [NUM_PINS-1:0]      en_q;
    logic [NUM_PINS-1:0][2:0] ty_q;
    logic [NUM_PINS-1:0]      cfg_wr;

    wkn_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .EN_BASE  (EN_BASE),
        .TY_BASE  (TY_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_q      (en_q),
        .ty_q      (ty_q),
        .cfg_wr    (cfg_wr)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cond
        wkn_pin u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (wake_in[p]),
            .pin_en (en_q[p]),
            .cfg    (ty_q[p]),
            .cfg_wr (cfg_wr[p]),
            .irq    (irq_out[p])
        );
    end

endmodule

// File: tb/test_wake_irq_normalizer.sv
module test_wake_irq_normalizer;

    localparam int N  = 40;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  wake_in = '0;
    logic [N-1:0]  irq_out;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    wake_irq_normalizer #(.NUM_PINS(N), .ADDR_W(AW)) i_wake_irq_normalizer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wake_in   (wake_in),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        reg_rd = 1'b1; reg_addr = AW'(addr);
        @(negedge clk);
        reg_rd = 1'b0;
        data = reg_rdata;
    endtask

    // five samples, one per falling clock edge, MSB first
    task automatic watch(input int p, input logic [4:0] exp, input string req);
        logic [4:0] got;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            got[4-i] = irq_out[p];
        end
        chk(req, 32'(got), 32'(exp));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", 32'(irq_out), 32'h0);
        rd('h10, d);  chk("R1 enable word0", d, 32'h0);
        rd('h14, d);  chk("R1 enable word1", d, 32'h0);
        rd('h110, d); chk("R1 type pin0", d, 32'h4);
        rd('h110 + 4*39, d); chk("R1 type pin39", d, 32'h4);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr('h10, 32'hFFFF_FFFF);
        rd('h10, d);  chk("R2 full word", d, 32'hFFFF_FFFF);
        wr('h14, 32'hFFFF_FFFF);
        rd('h14, d);  chk("R2 partial word", d, 32'h0000_00FF);
        rd('h18, d);  chk("R2 past last word", d, 32'h0);
        wr('h14, 32'h0);
        rd('h14, d);  chk("R2 cleared", d, 32'h0);
        wr('h110 + 4*3, 32'h1);
        rd('h110 + 4*3, d); chk("R3 code 001 ignored", d, 32'h4);
        wr('h110 + 4*3, 32'h2);
        rd('h110 + 4*3, d); chk("R3 falling accepted", d, 32'h2);
        wr('h110 + 4*3, 32'h5);
        rd('h110 + 4*3, d); chk("R3 code 101 ignored", d, 32'h2);
        wr('h110 + 4*3, 32'h3);
        rd('h110 + 4*3, d); chk("R3 code 011 ignored", d, 32'h2);
        rd('h110 + 4*60, d); chk("R2 unmapped type slot", d, 32'h0);
    endtask

    task automatic t_level_hi;
        wake_in[0] = 1'b1; watch(0, 5'b00111, "R4 high level rise");
        wake_in[0] = 1'b0; watch(0, 5'b11000, "R4 high level fall");
    endtask

    task automatic t_level_lo;
        wr('h110 + 4*1, 32'h0);
        watch(1, 5'b01111, "R5 low level idle high");
        wake_in[1] = 1'b1; watch(1, 5'b11000, "R5 low level input high");
        wake_in[1] = 1'b0; watch(1, 5'b00111, "R5 low level input low");
    endtask

    task automatic t_rise;
        wr('h110 + 4*2, 32'h6);
        watch(2, 5'b00000, "R6 after retype");
        wake_in[2] = 1'b1; watch(2, 5'b00100, "R6 rising pulse");
        wake_in[2] = 1'b0; watch(2, 5'b00000, "R6 falling ignored");
    endtask

    task automatic t_fall;
        wake_in[3] = 1'b1; watch(3, 5'b00000, "R7 rising ignored");
        wake_in[3] = 1'b0; watch(3, 5'b00100, "R7 falling pulse");
    endtask

    task automatic t_dual;
        wr('h110 + 4*4, 32'h7);
        watch(4, 5'b00000, "R8 after retype");
        wake_in[4] = 1'b1; watch(4, 5'b00100, "R8 rise pulse");
        wake_in[4] = 1'b0; watch(4, 5'b00100, "R8 fall pulse");
    endtask

    task automatic t_disable;
        wr('h10, 32'hFFFF_FFFB);
        wake_in[2] = 1'b1; watch(2, 5'b00000, "R9 edge while disabled");
        wr('h10, 32'hFFFF_FFFF);
        watch(2, 5'b00000, "R9 dropped edge not replayed");
        wake_in[2] = 1'b0;
        wr('h10, 32'hFFFF_FFFE);
        wake_in[0] = 1'b1; watch(0, 5'b00000, "R9 level masked");
        wr('h10, 32'hFFFF_FFFF);
        watch(0, 5'b01111, "R9 level resumes");
        wake_in[0] = 1'b0;
    endtask

    task automatic t_retype;
        // pin 5: active low, input low -> high request
        wr('h110 + 4*5, 32'h0);
        watch(5, 5'b01111, "R10 setup low level");
        wr('h110 + 4*5, 32'h6);
        chk("R10 old config at write", 32'(irq_out[5]), 32'h1);
        watch(5, 5'b00000, "R10 low level to rising");
        wr('h110 + 4*5, 32'h7);
        watch(5, 5'b00000, "R10 rising to dual");
        wake_in[5] = 1'b1;
        watch(5, 5'b00100, "R10 dual still live");
        wr('h110 + 4*5, 32'h2);
        watch(5, 5'b00000, "R10 dual to falling, input high");
        wr('h110 + 4*5, 32'h6);
        watch(5, 5'b00000, "R10 falling to rising, input high");
        // pin 6: same code rewritten gives one low cycle
        wake_in[6] = 1'b1;
        watch(6, 5'b00111, "R10 setup high level");
        wr('h110 + 4*6, 32'h4);
        chk("R10 level before hold", 32'(irq_out[6]), 32'h1);
        watch(6, 5'b01111, "R10 one held-low cycle");
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_level_hi();
        t_level_lo();
        t_rise();
        t_fall();
        t_dual();
        t_disable();
        t_retype();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule